// File: doc/BRIEF.md
# Variable-Rate Sample Request Pacer

This block paces the audio sample exchange between a codec and its link controller when the converters run slower than the fixed 48 kHz link frame. On each frame-start strobe it decides whether the playback side asks the controller for a new left/right sample pair, and whether the record side delivers a new captured pair in that frame. Playback and record each keep their own rate setting, and both channels of one direction always share that rate.

Each rate setting sits in a small register. A value written to it is replaced by the nearest supported rate, and the register reads back that replacement. Pacing uses a phase accumulator per direction. On every frame the accumulator adds the programmed rate, modulo 48000. A frame in which the sum wraps produces a request or a valid flag. When variable-rate operation is disabled, every frame produces one.

Top module: `vra_pacer`

## Requirements
- R1: After reset both rate readbacks are 48000, both playback request bits are 1 (inactive), the record-valid flag is 0 and both accumulators are 0.
- R2: A written rate is replaced by the nearest member of {8000, 11025, 16000, 22050, 24000, 32000, 44100, 48000}. A value exactly midway between two members takes the lower one. Values below 8000 give 8000 and values above 48000 give 48000. The readback shows the replaced value from the cycle after the write.
- R3: `cfg_sel` = 0 writes the playback rate and `cfg_sel` = 1 writes the record rate. A write to one direction leaves the other direction's readback unchanged. The two directions pace independently.
- R4: With `vra_en` high, on each `frame_tick` a direction adds its rate to its accumulator. If the sum is at least 48000, it subtracts 48000 and flags that frame. Otherwise it keeps the sum and does not flag. As a result, 24000 flags every second frame, starting with the second frame.
- R5: With `vra_en` low, every frame is flagged and the accumulators are held at 0. A rate of 48000 also flags every frame.
- R6: The playback request is active-low on two bits (bit 0 left, bit 1 right), and both bits always carry the same value. A value of 0 means the controller must send a sample pair in the next frame. `adc_valid` is active-high.
- R7: The flags are registered. They change only on the clock edge at which `frame_tick` is high and hold their value until the next strobe. A rate written in the same cycle as a strobe takes effect from the following strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe at each link frame start |
| vra_en | input | 1 | Variable-rate enable; low forces a flag on every frame |
| cfg_wr_en | input | 1 | Rate write strobe |
| cfg_sel | input | 1 | Write target: 0 playback, 1 record |
| cfg_wr_data | input | 16 | Rate to write, in Hz |
| dac_rate_rd | output | 16 | Snapped playback rate readback |
| adc_rate_rd | output | 16 | Snapped record rate readback |
| dac_req_n | output | 2 | Active-low playback sample request, {right, left} |
| adc_valid | output | 1 | Record sample pair valid in this frame |

## Verification
The bench writes values on both sides of every midpoint, and writes the exact midpoints that divide evenly. A design that rounded the wrong way, or broke ties upward, would read back the neighbouring rate. It runs 8000, 11025, 24000 and 44100 Hz over long frame spans and compares each frame against a running accumulator. An off-by-one wrap compare would drift by a frame, and the 48000 case would lose its every-frame request. It also sets the two directions to different rates, writes during a strobe, and toggles the enable. These catch crossed registers, a rate change applied in the same frame, and an accumulator left stale when variable-rate mode resumes.

// File: rtl/vra_pace_pkg.sv
package vra_pace_pkg;
  localparam int FRAME_HZ = 48000;
  localparam int RATE_W   = 16;
  localparam int N_RATES  = 8;

  function automatic logic [RATE_W-1:0] rate_at(input int idx);
    case (idx)
      0:       return 16'd8000;
      1:       return 16'd11025;
      2:       return 16'd16000;
      3:       return 16'd22050;
      4:       return 16'd24000;
      5:       return 16'd32000;
      6:       return 16'd44100;
      default: return 16'd48000;
    endcase
  endfunction

  // nearest member; midpoint ties keep the lower member
  function automatic logic [RATE_W-1:0] snap_rate(input logic [RATE_W-1:0] v);
    logic [RATE_W-1:0] r;
    r = rate_at(0);
    for (int i = 1; i < N_RATES; i++) begin
      if ({1'b0, v, 1'b0} > ({2'b00, rate_at(i-1)} + {2'b00, rate_at(i)}))
        r = rate_at(i);
    end
    return r;
  endfunction

  function automatic logic is_supported(input logic [RATE_W-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N_RATES; i++) if (v == rate_at(i)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/vra_rate_reg.sv
module vra_rate_reg
  import vra_pace_pkg::*;
#(
  parameter int W = RATE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rate
);
  logic [W-1:0] snapped;

  always_comb snapped = snap_rate(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rate <= W'(FRAME_HZ);
    else if (wr_en) rate <= snapped;
  end
endmodule

// File: rtl/vra_phase_acc.sv
module vra_phase_acc
  import vra_pace_pkg::*;
#(
  parameter int W      = RATE_W,
  parameter int MODULO = FRAME_HZ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         enable,
  input  logic [W-1:0] rate,
  output logic         flag
);
  localparam int SW = W + 1;

  logic [W-1:0]  acc;
  logic [SW-1:0] sum;
  logic          wrap;

  always_comb begin
    sum  = {1'b0, acc} + {1'b0, rate};
    wrap = (sum >= SW'(MODULO));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      flag <= 1'b0;
    end else if (tick) begin
      if (!enable) begin
        acc  <= '0;
        flag <= 1'b1;
      end else if (wrap) begin
        acc  <= W'(sum - SW'(MODULO));
        flag <= 1'b1;
      end else begin
        acc  <= W'(sum);
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vra_pacer.sv
module vra_pacer
  import vra_pace_pkg::*;
#(
  parameter int W     = RATE_W,
  parameter int N_DIR = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_tick,
  input  logic         vra_en,
  input  logic         cfg_wr_en,
  input  logic         cfg_sel,
  input  logic [W-1:0] cfg_wr_data,
  output logic [W-1:0] dac_rate_rd,
  output logic [W-1:0] adc_rate_rd,
  output logic [1:0]   dac_req_n,
  output logic         adc_valid
);
  logic [W-1:0]     rate [N_DIR];
  logic [N_DIR-1:0] flag;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    logic sel_hit;
    always_comb sel_hit = cfg_wr_en && (cfg_sel == d[0]);

    vra_rate_reg #(.W(W)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (sel_hit),
      .wr_data(cfg_wr_data),
      .rate   (rate[d])
    );

    vra_phase_acc #(.W(W), .MODULO(FRAME_HZ)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (frame_tick),
      .enable(vra_en),
      .rate  (rate[d]),
      .flag  (flag[d])
    );
  end

  assign dac_rate_rd = rate[0];
  assign adc_rate_rd = rate[1];
  assign dac_req_n   = {2{~flag[0]}};
  assign adc_valid   = flag[1];
endmodule

// File: rtl/vra_pacer_checker.sv
module vra_pacer_checker
  import vra_pace_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        frame_tick,
  input logic        vra_en,
  input logic        cfg_wr_en,
  input logic        cfg_sel,
  input logic [15:0] dac_rate_rd,
  input logic [15:0] adc_rate_rd,
  input logic [1:0]  dac_req_n,
  input logic        adc_valid
);
  a_r2_rate_supported: assert property (@(posedge clk) disable iff (!rst_n)
    is_supported(dac_rate_rd) && is_supported(adc_rate_rd));

  a_r3_dac_write_keeps_adc: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_sel) |=> $stable(adc_rate_rd));

  a_r3_adc_write_keeps_dac: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_sel) |=> $stable(dac_rate_rd));

  a_r5_disabled_every_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !vra_en) |=> (dac_req_n == 2'b00) && adc_valid);

  a_r5_full_rate_every_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && dac_rate_rd == 16'd48000) |=> (dac_req_n == 2'b00));

  a_r6_channels_match: assert property (@(posedge clk) disable iff (!rst_n)
    dac_req_n[0] == dac_req_n[1]);

  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(dac_req_n) && $stable(adc_valid)));
endmodule

bind vra_pacer vra_pacer_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .vra_en     (vra_en),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_sel    (cfg_sel),
  .dac_rate_rd(dac_rate_rd),
  .adc_rate_rd(adc_rate_rd),
  .dac_req_n  (dac_req_n),
  .adc_valid  (adc_valid)
);

// File: tb/vra_pacer_test.sv
`timescale 1ns/1ps
module vra_pacer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic        vra_en = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] dac_rate_rd, adc_rate_rd;
  logic [1:0]  dac_req_n;
  logic        adc_valid;

  int checks = 0;
  int errors = 0;
  int acc_d = 0;
  int acc_a = 0;

  always #2.5 clk = ~clk;

  vra_pacer uut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .vra_en(vra_en),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wr_data(cfg_wr_data),
    .dac_rate_rd(dac_rate_rd), .adc_rate_rd(adc_rate_rd),
    .dac_req_n(dac_req_n), .adc_valid(adc_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_rate(input bit sel, input int val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wr_data = 16'(val);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // reference accumulator from R4/R5
  function automatic bit model(ref int acc, input int rate, input bit en);
    if (!en) begin acc = 0; return 1'b1; end
    acc += rate;
    if (acc >= 48000) begin acc -= 48000; return 1'b1; end
    return 1'b0;
  endfunction

  // one frame strobe, then compare both flags with the model
  task automatic frame(input string req);
    bit ed, ea;
    ed = model(acc_d, int'(dac_rate_rd), vra_en);
    ea = model(acc_a, int'(adc_rate_rd), vra_en);
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    check({req, " dac_req_n"}, int'(dac_req_n), ed ? 0 : 3);
    check({req, " adc_valid"}, int'(adc_valid), int'(ea));
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 dac rate", int'(dac_rate_rd), 48000);
    check("R1 adc rate", int'(adc_rate_rd), 48000);
    check("R1 dac_req_n", int'(dac_req_n), 3);
    check("R1 adc_valid", int'(adc_valid), 0);
  endtask

  task automatic t_snap();
    int wv[14] = '{0, 8000, 9512, 9513, 13512, 13513, 19025, 19026,
                   23025, 23026, 28000, 46050, 46051, 65535};
    int ev[14] = '{8000, 8000, 8000, 11025, 11025, 16000, 16000, 22050,
                   22050, 24000, 24000, 44100, 48000, 48000};
    for (int i = 0; i < 14; i++) begin
      write_rate(1'b0, wv[i]);
      check("R2 snap dac", int'(dac_rate_rd), ev[i]);
    end
    write_rate(1'b1, 38050);
    check("R2 snap adc tie", int'(adc_rate_rd), 32000);
  endtask

  task automatic t_independent();
    write_rate(1'b0, 11025);
    write_rate(1'b1, 44100);
    check("R3 dac kept", int'(dac_rate_rd), 11025);
    check("R3 adc set", int'(adc_rate_rd), 44100);
    write_rate(1'b1, 16000);
    check("R3 dac untouched", int'(dac_rate_rd), 11025);
  endtask

  task automatic t_disabled();
    vra_en = 1'b0;
    write_rate(1'b0, 8000);
    write_rate(1'b1, 8000);
    for (int i = 0; i < 4; i++) frame("R5 disabled");
  endtask

  task automatic t_half();
    vra_en = 1'b1;
    write_rate(1'b0, 24000);
    write_rate(1'b1, 48000);
    for (int i = 0; i < 6; i++) frame("R4 24k");
    check("R6 left/right equal", int'(dac_req_n[0]), int'(dac_req_n[1]));
  endtask

  task automatic t_long(input int rd, input int ra, input int n, input string req);
    write_rate(1'b0, rd);
    write_rate(1'b1, ra);
    for (int i = 0; i < n; i++) frame(req);
  endtask

  task automatic t_hold();
    logic [1:0] rq;
    logic       av;
    rq = dac_req_n; av = adc_valid;
    repeat (10) @(negedge clk);
    check("R7 hold dac", int'(dac_req_n), int'(rq));
    check("R7 hold adc", int'(adc_valid), int'(av));
  endtask

  task automatic t_write_on_tick();
    bit ed, ea;
    write_rate(1'b0, 8000);
    // strobe and write together: this frame still uses 8000
    ed = model(acc_d, 8000, 1'b1);
    ea = model(acc_a, int'(adc_rate_rd), 1'b1);
    @(negedge clk);
    frame_tick = 1'b1; cfg_wr_en = 1'b1; cfg_sel = 1'b0; cfg_wr_data = 16'd48000;
    @(negedge clk);
    frame_tick = 1'b0; cfg_wr_en = 1'b0;
    check("R7 same-cycle write dac", int'(dac_req_n), ed ? 0 : 3);
    check("R7 same-cycle write adc", int'(adc_valid), int'(ea));
    frame("R7 new rate applied");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_snap();
    t_independent();
    t_disabled();
    t_half();
    t_long(44100, 8000, 96, "R4 44k1/8k");
    t_long(11025, 32000, 640, "R4 11k025/32k");
    t_hold();
    t_write_on_tick();
    vra_en = 1'b0;
    frame("R5 re-disable");
    vra_en = 1'b1;
    t_long(24000, 22050, 8, "R5 resume from zero");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule